// File: doc/BRIEF.md
# DDR Read Window Pulse Generator

This block sits in the core clock domain beside a DDR SDRAM read path. It produces the read-window pulse that the strobe capture buffer uses to find the strobe preamble. The pulse rises in the same cycle that the controller issues a read command. It then stays high for a programmed number of cycles, so that its falling edge lands inside the preamble, before the strobe's first rising transition. That number is worked out from the CAS latency plus the measured board round-trip delay.

Software sets the CAS latency and the round-trip delay through a small write port and can read both values back. A read command that arrives while a window is still open restarts the timing. The window then closes only after the later command's full length, so overlapping bursts never cut a window short. In the last cycle of each window the block samples the external preamble-detect flag. From that sample it records whether the placement passed, and it keeps a saturating count of failed placements until software clears the result.

Top module: `ddr_rd_window_gen`

## Requirements
- R1: `rd_window_o` is high in every cycle in which `rd_cmd_i` is high, with no register between them.
- R2: After a lone command, `rd_window_o` stays high for exactly W consecutive cycles, the command cycle included. W = CAS - 1 + RTD, and W is raised to 1 when that sum is 0.
- R3: A command that arrives while a window is open restarts the count. The output stays high for W cycles counted from the later command.
- R4: W is taken from the configuration held at the moment of the command. A configuration write, including one in the same cycle as a command, affects only later commands.
- R5: `cfg_cas_wr_i` is a 2-bit field and `cfg_rtd_wr_i` is a 3-bit field, both stored when `cfg_we_i` is high. A CAS value below 2 is stored as 2. The stored values appear on `cfg_cas_o` and `cfg_rtd_o` one cycle after the write.
- R6: In the final high cycle of a window, `prmb_det_i` is sampled. From the next cycle on, `stat_valid_o` is 1 and `stat_pass_o` equals the sampled value (1 = OK, 0 = FAIL).
- R7: Each window that ends with `prmb_det_i` low adds one to `fail_cnt_o`. The count saturates at 2^FCNT_W - 1.
- R8: `stat_clr_i` clears `stat_valid_o`, `stat_pass_o` and `fail_cnt_o` on the next edge. It wins over a window that ends in the same cycle, and the result of that window is dropped.
- R9: While reset is asserted, the status outputs are 0, CAS reads 2, RTD reads 0, and `rd_window_o` is low unless a command is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_cmd_i | input | 1 | Read command issued to memory this cycle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_cas_wr_i | input | CL_W | CAS latency to store |
| cfg_rtd_wr_i | input | RTD_W | Round-trip delay in cycles to store |
| stat_clr_i | input | 1 | Clear status (write-one-to-clear) |
| prmb_det_i | input | 1 | Preamble-detect flag from the capture buffer |
| rd_window_o | output | 1 | Read window pulse |
| cfg_cas_o | output | CL_W | Stored CAS latency |
| cfg_rtd_o | output | RTD_W | Stored round-trip delay |
| stat_valid_o | output | 1 | At least one result recorded since clear |
| stat_pass_o | output | 1 | Result of the last completed window |
| fail_cnt_o | output | FCNT_W | Saturating count of failed windows |

## Verification
The bench targets a command that lands inside an open window. A design that ignored it, or that added to the remaining count instead of reloading it, would close the window early or late. It also places a configuration write in the same cycle as a command, which exposes a design that picks up the new width too soon. It drives low CAS values, which would yield a zero-length window if they were not clamped. Finally, a clear that coincides with a window's end, and a long run of failed windows, show whether the clear priority and the counter saturation hold, or whether the count wraps to zero.

// File: rtl/ddr_rdwin_pkg.sv
package ddr_rdwin_pkg;

  // Outcome of one window: preamble seen at the falling edge or not
  typedef enum logic {
    RES_FAIL = 1'b0,
    RES_OK   = 1'b1
  } rdwin_res_e;

  typedef struct packed {
    logic       valid;
    rdwin_res_e res;
  } rdwin_stat_t;

endpackage

// File: rtl/ddr_rdwin_cfg.sv
module ddr_rdwin_cfg #(
  parameter int CL_W   = 2,
  parameter int RTD_W  = 3,
  parameter int CL_MIN = 2,
  parameter int CL_MAX = 3,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CL_W-1:0]  cas_wr_i,
  input  logic [RTD_W-1:0] rtd_wr_i,
  output logic [CL_W-1:0]  cas_o,
  output logic [RTD_W-1:0] rtd_o,
  output logic [CNT_W-1:0] width_o
);

  localparam int SUM_W = CNT_W + 1;

  logic [CL_W-1:0]  cas_q, cas_d, cas_clamped;
  logic [RTD_W-1:0] rtd_q, rtd_d;
  logic [SUM_W-1:0] sum;

  // Keep CAS inside the supported range
  always_comb begin
    cas_clamped = cas_wr_i;
    if (int'(cas_wr_i) < CL_MIN) cas_clamped = CL_W'(CL_MIN);
    if (int'(cas_wr_i) > CL_MAX) cas_clamped = CL_W'(CL_MAX);
  end

  always_comb begin
    cas_d = cas_q;
    rtd_d = rtd_q;
    if (we_i) begin
      cas_d = cas_clamped;
      rtd_d = rtd_wr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_q <= CL_W'(CL_MIN);
      rtd_q <= '0;
    end else begin
      cas_q <= cas_d;
      rtd_q <= rtd_d;
    end
  end

  // Window width: CAS - 1 + RTD, at least one cycle
  always_comb begin
    sum     = SUM_W'(cas_q) + SUM_W'(rtd_q) - SUM_W'(1);
    width_o = (sum == '0) ? CNT_W'(1) : sum[CNT_W-1:0];
  end

  assign cas_o = cas_q;
  assign rtd_o = rtd_q;

  AST_CAS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cas_q) >= CL_MIN) && (int'(cas_q) <= CL_MAX)); // R5
  AST_WIDTH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    width_o != '0); // R2

endmodule

// File: rtl/ddr_rdwin_timer.sv
module ddr_rdwin_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             win_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // cnt_q holds the window cycles still owed after the current one
  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = width_i - CNT_W'(1);
    else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign win_o  = load_i || (cnt_q != '0);
  assign last_o = win_o && (cnt_d == '0);

  AST_RELOAD_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(width_i) - CNT_W'(1))); // R3
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2

endmodule

// File: rtl/ddr_rdwin_status.sv
module ddr_rdwin_status
  import ddr_rdwin_pkg::*;
#(
  parameter int FCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              end_i,
  input  logic              det_i,
  output logic              valid_o,
  output logic              pass_o,
  output logic [FCNT_W-1:0] fcnt_o
);

  localparam logic [FCNT_W-1:0] FCNT_MAX = '1;

  rdwin_stat_t       stat_q, stat_d;
  logic [FCNT_W-1:0] fcnt_q, fcnt_d;

  always_comb begin
    stat_d = stat_q;
    fcnt_d = fcnt_q;
    if (clr_i) begin
      stat_d = '{valid: 1'b0, res: RES_FAIL};
      fcnt_d = '0;
    end else if (end_i) begin
      stat_d.valid = 1'b1;
      stat_d.res   = det_i ? RES_OK : RES_FAIL;
      if (!det_i && fcnt_q != FCNT_MAX) fcnt_d = fcnt_q + FCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '{valid: 1'b0, res: RES_FAIL};
      fcnt_q <= '0;
    end else begin
      stat_q <= stat_d;
      fcnt_q <= fcnt_d;
    end
  end

  assign valid_o = stat_q.valid;
  assign pass_o  = (stat_q.res == RES_OK);
  assign fcnt_o  = fcnt_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!valid_o && !pass_o && fcnt_o == '0)); // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (fcnt_o >= $past(fcnt_o))); // R7
  AST_RESULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && !clr_i) |=> (valid_o && pass_o == $past(det_i))); // R6

endmodule

// File: rtl/ddr_rd_window_gen.sv
module ddr_rd_window_gen #(
  parameter int CL_W   = 2,
  parameter int RTD_W  = 3,
  parameter int CL_MIN = 2,
  parameter int CL_MAX = 3,
  parameter int FCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd_i,
  input  logic              cfg_we_i,
  input  logic [CL_W-1:0]   cfg_cas_wr_i,
  input  logic [RTD_W-1:0]  cfg_rtd_wr_i,
  input  logic              stat_clr_i,
  input  logic              prmb_det_i,
  output logic              rd_window_o,
  output logic [CL_W-1:0]   cfg_cas_o,
  output logic [RTD_W-1:0]  cfg_rtd_o,
  output logic              stat_valid_o,
  output logic              stat_pass_o,
  output logic [FCNT_W-1:0] fail_cnt_o
);

  localparam int W_MAX = CL_MAX - 1 + (1 << RTD_W) - 1;
  localparam int CNT_W = $clog2(W_MAX + 1);

  logic [CNT_W-1:0] width;
  logic             win_last;

  ddr_rdwin_cfg #(
    .CL_W  (CL_W),
    .RTD_W (RTD_W),
    .CL_MIN(CL_MIN),
    .CL_MAX(CL_MAX),
    .CNT_W (CNT_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we_i),
    .cas_wr_i(cfg_cas_wr_i),
    .rtd_wr_i(cfg_rtd_wr_i),
    .cas_o   (cfg_cas_o),
    .rtd_o   (cfg_rtd_o),
    .width_o (width)
  );

  ddr_rdwin_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (rd_cmd_i),
    .width_i(width),
    .win_o  (rd_window_o),
    .last_o (win_last)
  );

  ddr_rdwin_status #(
    .FCNT_W(FCNT_W)
  ) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (stat_clr_i),
    .end_i  (win_last),
    .det_i  (prmb_det_i),
    .valid_o(stat_valid_o),
    .pass_o (stat_pass_o),
    .fcnt_o (fail_cnt_o)
  );

  AST_LAST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |-> rd_window_o); // R6
  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && !rd_cmd_i) |=> !rd_window_o || rd_cmd_i); // R2

endmodule

// File: tb/ddr_rd_window_gen_tb.sv
`timescale 1ns/1ps
module ddr_rd_window_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_cmd_i, cfg_we_i, stat_clr_i, prmb_det_i;
  logic [1:0] cfg_cas_wr_i;
  logic [2:0] cfg_rtd_wr_i;
  logic       rd_window_o, stat_valid_o, stat_pass_o;
  logic [1:0] cfg_cas_o;
  logic [2:0] cfg_rtd_o;
  logic [7:0] fail_cnt_o;

  int n_chk = 0;
  int n_err = 0;
  string cur_tag = "R2";

  // reference state
  int m_cnt, m_cas, m_rtd, m_fcnt;
  bit m_valid, m_pass;

  always #2.5 clk = ~clk;

  ddr_rd_window_gen u_dut (
    .clk(clk), .rst_n(rst_n), .rd_cmd_i(rd_cmd_i), .cfg_we_i(cfg_we_i),
    .cfg_cas_wr_i(cfg_cas_wr_i), .cfg_rtd_wr_i(cfg_rtd_wr_i),
    .stat_clr_i(stat_clr_i), .prmb_det_i(prmb_det_i),
    .rd_window_o(rd_window_o), .cfg_cas_o(cfg_cas_o), .cfg_rtd_o(cfg_rtd_o),
    .stat_valid_o(stat_valid_o), .stat_pass_o(stat_pass_o),
    .fail_cnt_o(fail_cnt_o)
  );

  function automatic int exp_width(int cas, int rtd);
    int w = cas - 1 + rtd;
    return (w < 1) ? 1 : w;
  endfunction

  function automatic int clamp_cas(int v);
    return (v < 2) ? 2 : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  task automatic step(bit cmd, bit we, int cas, int rtd, bit clr, bit det);
    bit exp_win, last;
    int cnt_n;
    @(negedge clk);
    rd_cmd_i = cmd; cfg_we_i = we; cfg_cas_wr_i = 2'(cas);
    cfg_rtd_wr_i = 3'(rtd); stat_clr_i = clr; prmb_det_i = det;
    #1;
    exp_win = cmd || (m_cnt != 0);
    chk(cmd ? "R1" : cur_tag, int'(rd_window_o), int'(exp_win));
    chk("R6", int'(stat_valid_o), int'(m_valid));
    chk("R6", int'(stat_pass_o), int'(m_pass));
    chk("R7", int'(fail_cnt_o), m_fcnt);
    chk("R5", int'(cfg_cas_o), m_cas);
    chk("R5", int'(cfg_rtd_o), m_rtd);
    // advance the reference model by one edge
    cnt_n = cmd ? exp_width(m_cas, m_rtd) - 1 : ((m_cnt != 0) ? m_cnt - 1 : 0);
    last  = exp_win && (cnt_n == 0);
    if (clr) begin
      m_valid = 0; m_pass = 0; m_fcnt = 0;
    end else if (last) begin
      m_valid = 1; m_pass = det;
      if (!det && m_fcnt < 255) m_fcnt++;
    end
    if (we) begin
      m_cas = clamp_cas(cas & 3); m_rtd = rtd & 7;
    end
    m_cnt = cnt_n;
  endtask

  task automatic idle(int n, bit det);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, det);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = 0; m_cas = 2; m_rtd = 0; m_fcnt = 0; m_valid = 0; m_pass = 0;
    rst_n = 1'b0; rd_cmd_i = 0; cfg_we_i = 0; cfg_cas_wr_i = 0;
    cfg_rtd_wr_i = 0; stat_clr_i = 0; prmb_det_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R9: reset state
    chk("R9", int'(rd_window_o), 0);
    chk("R9", int'(stat_valid_o), 0);
    chk("R9", int'(stat_pass_o), 0);
    chk("R9", int'(fail_cnt_o), 0);
    chk("R9", int'(cfg_cas_o), 2);
    chk("R9", int'(cfg_rtd_o), 0);
    rst_n = 1'b1;

    // R2: default width 1
    cur_tag = "R2";
    step(1, 0, 0, 0, 0, 1); idle(3, 0);
    // R2: width 7 (CAS 3, RTD 5)
    step(0, 1, 3, 5, 0, 0);
    step(1, 0, 0, 0, 0, 0); idle(10, 1);
    // R3: restart inside an open window
    cur_tag = "R3";
    step(1, 0, 0, 0, 0, 0); idle(3, 0);
    step(1, 0, 0, 0, 0, 0); idle(10, 0);
    // R4: write in the command cycle keeps the old width
    cur_tag = "R4";
    step(1, 1, 2, 0, 0, 0); idle(9, 1);
    step(1, 0, 0, 0, 0, 1); idle(2, 1);
    // R5: low CAS values clamp to 2
    cur_tag = "R5";
    step(0, 1, 0, 4, 0, 0); idle(1, 0);
    step(0, 1, 1, 7, 0, 0); idle(1, 0);
    step(1, 0, 0, 0, 0, 0); idle(10, 0);
    // R6: pass then fail at width 1
    cur_tag = "R6";
    step(0, 1, 2, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1); idle(1, 0);
    step(1, 0, 0, 0, 0, 0); idle(1, 0);
    // R8: clear coinciding with a window end
    cur_tag = "R8";
    step(1, 0, 0, 0, 1, 0); idle(2, 0);
    // R7: saturation of the failure count
    cur_tag = "R7";
    for (int i = 0; i < 262; i++) step(1, 0, 0, 0, 0, 0);
    idle(2, 0);
    step(0, 0, 0, 0, 1, 0); idle(1, 0);
    // random mix
    cur_tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) == 0, ($urandom % 12) == 0, int'($urandom % 4),
           int'($urandom % 8), ($urandom % 40) == 0, $urandom % 2);
    end
    summary();
  end

endmodule